// File: doc/BRIEF.md
# Timer-Based PWM Generator

This block turns an up-counting time-stamp counter into a single-channel PWM source. Software programs a period length and a compare (duty) value through a small word-addressed register port. It then starts the counter and enables the output from a control register. The output pin is high while the counter is below the compare value and low for the rest of the period. An invert bit swaps the two levels.

Each of the period and compare values has an active copy and a shadow copy. While the counter runs, the active copies are frozen. Software writes new values into the shadow copies instead. A shadow copy moves into its active copy on the cycle the counter wraps, but only if that shadow was written since the previous wrap. The period in progress therefore always finishes with the values it started with. While the counter is stopped, software writes the active copies directly and can preset the counter. The first period then needs no boundary. A counter write made while the counter runs is dropped.

Top module: `pwmt_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register (counter, active and shadow period and compare, control) becomes 0, and `pwm_out` is low from the following edge.
- R2: Registers sit at word addresses 0 counter, 1 active period, 2 active compare, 3 shadow period, 4 shadow compare, 5 control (16 bits, upper 16 read as 0). Each reads back the value last written. Addresses 6 and 7 read 0 and ignore writes.
- R3: Control bit 0 (run) makes the counter advance by one every clock. With bit 0 clear the counter holds its value, and a write to address 0 presets it.
- R4: With active period P (P of 0 treated as 1), the counter counts 0 up to P-1 and then returns to 0, so a period lasts P cycles.
- R5: With control bit 2 clear, `pwm_out` shows, one clock after the counter holds value n, high when n is below the active compare value and low otherwise. A compare value of P or more gives a constant high output.
- R6: Control bit 2 (invert) inverts the level described in R5, so the compare value sets the length of the low part of the period.
- R7: With control bit 1 (output enable) clear, `pwm_out` is low from the next edge, whatever the counter does.
- R8: A shadow period or shadow compare write made while running leaves the period in progress unchanged. The value is copied into the active register on the wrap cycle, and the following periods use it.
- R9: Active period and compare writes take effect only while the counter is stopped. Such a write also cancels any pending copy from the matching shadow register.
- R10: Period 1 with compare 1 is legal: the counter stays at 0 and the output stays constantly high in normal polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Word address of the read |
| rd_data | output | 32 | Read data for `rd_addr`, combinational |
| pwm_out | output | 1 | PWM output |

## Verification
On every cycle, the assertions check four things. The active period and compare stay frozen inside a running period. A running counter only steps by one or returns to 0, and a stopped counter holds unless it is preset. The output is low when it is disabled and after reset. Only the bench scenarios show the actual waveform shapes: the cycle-exact high and low lengths for several period and compare pairs, the inverted shape, and the constant-high cases. The scenarios also cover the handover from old to new values at a boundary, the dropped active write while running, and the cancelled pending copy.

// File: rtl/pwmt_pkg.sv
// Package: shared address map and control bit positions for the PWM timer.
// Assumes a 3-bit word address and a 32-bit data bus.
package pwmt_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CNT    = 3'd0,
        ADR_PER    = 3'd1,
        ADR_CMP    = 3'd2,
        ADR_PER_SH = 3'd3,
        ADR_CMP_SH = 3'd4,
        ADR_CTRL   = 3'd5
    } pwmt_addr_e;

    localparam int CTL_RUN    = 0;
    localparam int CTL_OUT_EN = 1;
    localparam int CTL_INVERT = 2;
endpackage

// File: rtl/pwmt_regs.sv
// Module: holds control, active and shadow period/compare registers.
// Active registers accept writes only while stopped; shadow registers load
// into their active copy on a wrap if written since the last wrap.
module pwmt_regs
    import pwmt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int CTRL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wrap,
    output logic [CNT_W-1:0]  per_act,
    output logic [CNT_W-1:0]  cmp_act,
    output logic [CNT_W-1:0]  per_sh,
    output logic [CNT_W-1:0]  cmp_sh,
    output logic [CTRL_W-1:0] ctrl
);
    localparam int NPAIR = 2;

    logic [CNT_W-1:0]  act_q [NPAIR];
    logic [CNT_W-1:0]  sh_q  [NPAIR];
    logic [NPAIR-1:0]  pend_q;
    logic [CTRL_W-1:0] ctrl_q;

    // Control register: plain write, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en && wr_addr == ADR_CTRL)
            ctrl_q <= wr_data[CTRL_W-1:0];
    end

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        localparam logic [ADDR_W-1:0] A_ACT = (g == 0) ? ADR_PER    : ADR_CMP;
        localparam logic [ADDR_W-1:0] A_SH  = (g == 0) ? ADR_PER_SH : ADR_CMP_SH;

        // One active/shadow pair with its pending-copy flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_q[g]  <= '0;
                sh_q[g]   <= '0;
                pend_q[g] <= 1'b0;
            end else begin
                if (wrap && pend_q[g]) begin
                    act_q[g]  <= sh_q[g];
                    pend_q[g] <= 1'b0;
                end
                if (wr_en && wr_addr == A_SH) begin
                    sh_q[g]   <= wr_data[CNT_W-1:0];
                    pend_q[g] <= 1'b1;
                end else if (wr_en && wr_addr == A_ACT && !ctrl_q[CTL_RUN]) begin
                    act_q[g]  <= wr_data[CNT_W-1:0];
                    pend_q[g] <= 1'b0;
                end
            end
        end
    end

    assign per_act = act_q[0];
    assign cmp_act = act_q[1];
    assign per_sh  = sh_q[0];
    assign cmp_sh  = sh_q[1];
    assign ctrl    = ctrl_q;
endmodule

// File: rtl/pwmt_counter.sv
// Module: up counter that wraps after reaching period-1 (period 0 acts as 1).
// Assumes preset requests arrive only while stopped; the top gates them.
module pwmt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             preset_en,
    input  logic [CNT_W-1:0] preset_val,
    input  logic [CNT_W-1:0] per_act,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             last;

    // Last count of the period, treating period 0 like period 1.
    always_comb begin
        if (per_act <= ONE)
            last = 1'b1;
        else
            last = (cnt_q >= per_act - ONE);
    end

    // Count, wrap, hold or preset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (run)
            cnt_q <= last ? '0 : cnt_q + ONE;
        else if (preset_en)
            cnt_q <= preset_val;
    end

    assign cnt  = cnt_q;
    assign wrap = run && last;
endmodule

// File: rtl/pwmt_wave.sv
// Module: compare, polarity and gating stage with a registered output.
// Output reflects the counter value of the previous cycle.
module pwmt_wave #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp_act,
    input  logic             out_en,
    input  logic             invert,
    output logic             pwm_out
);
    logic out_q;

    // Register the gated, polarity-adjusted compare result.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= 1'b0;
        else
            out_q <= out_en ? ((cnt < cmp_act) ^ invert) : 1'b0;
    end

    assign pwm_out = out_q;
endmodule

// File: rtl/pwmt_top.sv
// Module: timer-based PWM generator top: register port, counter, waveform.
// Assumes a single clock domain and a synchronous active-low reset.
module pwmt_top
    import pwmt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int CTRL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [2:0]        rd_addr,
    output logic [31:0]       rd_data,
    output logic              pwm_out
);
    logic [CNT_W-1:0]  per_act;
    logic [CNT_W-1:0]  cmp_act;
    logic [CNT_W-1:0]  per_sh;
    logic [CNT_W-1:0]  cmp_sh;
    logic [CTRL_W-1:0] ctrl;
    logic [CNT_W-1:0]  cnt;
    logic              wrap;
    logic              preset_en;

    assign preset_en = wr_en && (wr_addr == ADR_CNT) && !ctrl[CTL_RUN];

    pwmt_regs #(.CNT_W(CNT_W), .CTRL_W(CTRL_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wrap    (wrap),
        .per_act (per_act),
        .cmp_act (cmp_act),
        .per_sh  (per_sh),
        .cmp_sh  (cmp_sh),
        .ctrl    (ctrl)
    );

    pwmt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (ctrl[CTL_RUN]),
        .preset_en  (preset_en),
        .preset_val (wr_data[CNT_W-1:0]),
        .per_act    (per_act),
        .cnt        (cnt),
        .wrap       (wrap)
    );

    pwmt_wave #(.CNT_W(CNT_W)) u_wave (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt     (cnt),
        .cmp_act (cmp_act),
        .out_en  (ctrl[CTL_OUT_EN]),
        .invert  (ctrl[CTL_INVERT]),
        .pwm_out (pwm_out)
    );

    // Read multiplexer over the register map.
    always_comb begin
        case (rd_addr)
            ADR_CNT:    rd_data = DATA_W'(cnt);
            ADR_PER:    rd_data = DATA_W'(per_act);
            ADR_CMP:    rd_data = DATA_W'(cmp_act);
            ADR_PER_SH: rd_data = DATA_W'(per_sh);
            ADR_CMP_SH: rd_data = DATA_W'(cmp_sh);
            ADR_CTRL:   rd_data = DATA_W'(ctrl);
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/pwmt_checker.sv
// Module: temporal checks on the PWM timer, attached by bind.
// Assumes it sees the top's internal register and counter nets.
module pwmt_checker #(
    parameter int CNT_W  = 32,
    parameter int CTRL_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        wr_addr,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  per_act,
    input logic [CNT_W-1:0]  cmp_act,
    input logic [CTRL_W-1:0] ctrl,
    input logic              wrap,
    input logic              pwm_out
);
    // R1
    reset_low_chk: assert property (@(posedge clk) !rst_n |=> !pwm_out);

    // R7
    gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[1] |=> !pwm_out);

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[0] && !(wr_en && wr_addr == 3'd0)) |=> $stable(cnt));

    // R4
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[0] |=> (cnt == '0 || cnt == $past(cnt) + CNT_W'(1)));

    // R8
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[0] && !wrap) |=> ($stable(per_act) && $stable(cmp_act)));
endmodule

bind pwmt_top pwmt_checker #(.CNT_W(CNT_W), .CTRL_W(CTRL_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .cnt     (cnt),
    .per_act (per_act),
    .cmp_act (cmp_act),
    .ctrl    (ctrl),
    .wrap    (wrap),
    .pwm_out (pwm_out)
);

// File: tb/pwmt_top_tb.sv
module pwmt_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        pwm_out;

    int errs = 0;
    int checks = 0;

    always #4 clk = ~clk;

    pwmt_top u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .pwm_out (pwm_out)
    );

    // address, write value, expected read value
    localparam int NV = 7;
    localparam logic [66:0] VEC [NV] = '{
        {3'd0, 32'h0000_0003, 32'h0000_0003},
        {3'd1, 32'h0000_0011, 32'h0000_0011},
        {3'd2, 32'h0000_0022, 32'h0000_0022},
        {3'd3, 32'hA5A5_0001, 32'hA5A5_0001},
        {3'd4, 32'h5A5A_0002, 32'h5A5A_0002},
        {3'd5, 32'h0000_FF00, 32'h0000_FF00},
        {3'd6, 32'hDEAD_BEEF, 32'h0000_0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic run_cfg(input logic [31:0] per, input logic [31:0] cmp, input logic [31:0] ctl);
        wr(3'd5, 32'd0);
        wr(3'd0, 32'd0);
        wr(3'd1, per);
        wr(3'd2, cmp);
        wr(3'd5, ctl);
    endtask

    initial begin
        #(8 * 100000);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] v2;
        logic        e;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 out", {31'd0, pwm_out}, 32'd0);
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk("R1 reg", v, 32'd0);
        end
        rst_n = 1'b1;

        // R2 table walk
        for (int k = 0; k < NV; k++) begin
            wr(VEC[k][66:64], VEC[k][63:32]);
            rd(VEC[k][66:64], v);
            chk("R2 readback", v, VEC[k][31:0]);
        end

        // R4 R5 R8 R9: run P=5 C=2, shadow P=4 C=3 written mid-run
        run_cfg(32'd5, 32'd2, 32'd3);
        for (int i = 0; i < 22; i++) begin
            @(negedge clk);
            e = (i < 10) ? ((i % 5) < 2) : (((i - 10) % 4) < 3);
            chk("R5/R8 wave", {31'd0, pwm_out}, {31'd0, e});
            wr_en = 1'b0;
            if (i == 2) begin wr_en = 1'b1; wr_addr = 3'd1; wr_data = 32'd9; end
            if (i == 6) begin wr_en = 1'b1; wr_addr = 3'd3; wr_data = 32'd4; end
            if (i == 7) begin wr_en = 1'b1; wr_addr = 3'd4; wr_data = 32'd3; end
        end
        wr_en = 1'b0;
        wr(3'd5, 32'd0);
        @(negedge clk);
        chk("R7 stopped out", {31'd0, pwm_out}, 32'd0);
        rd(3'd1, v);
        chk("R8/R9 period", v, 32'd4);
        rd(3'd2, v);
        chk("R8 compare", v, 32'd3);
        rd(3'd0, v);
        repeat (3) @(negedge clk);
        rd(3'd0, v2);
        chk("R3 hold", v2, v);

        // R7 R3: running with output disabled
        run_cfg(32'd10, 32'd5, 32'd1);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R7 gated", {31'd0, pwm_out}, 32'd0);
            if (i == 2) begin
                rd(3'd0, v);
                chk("R3 count", v, 32'd3);
            end
        end

        // R6 inverted P=4 C=1
        run_cfg(32'd4, 32'd1, 32'd7);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            e = !((i % 4) < 1);
            chk("R6 invert", {31'd0, pwm_out}, {31'd0, e});
        end

        // R5 compare above period: constant high
        run_cfg(32'd3, 32'd7, 32'd3);
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            chk("R5 const high", {31'd0, pwm_out}, 32'd1);
        end

        // R10 minimum setting
        run_cfg(32'd1, 32'd1, 32'd3);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R10 min", {31'd0, pwm_out}, 32'd1);
        end
        rd(3'd0, v);
        chk("R10 counter", v, 32'd0);

        // R9 direct active write cancels a pending shadow copy
        wr(3'd5, 32'd0);
        wr(3'd3, 32'd2);
        wr(3'd0, 32'd0);
        wr(3'd1, 32'd6);
        wr(3'd2, 32'd3);
        wr(3'd5, 32'd3);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            e = (i % 6) < 3;
            chk("R9 cancel", {31'd0, pwm_out}, {31'd0, e});
        end

        // R1 reset while running
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 mid-run out", {31'd0, pwm_out}, 32'd0);
        rst_n = 1'b1;
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk("R1 mid-run reg", v, 32'd0);
        end

        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule